// File: doc/BRIEF.md
# Sparse Token-Scan Pixel Readout Controller

This block is the digital readout for a square matrix of hit pixels (64 columns by 64 rows by default). While the matrix is acquiring, every pixel that is hit, and not killed, latches the current value of a shared 5-bit time-stamp counter. The cell keeps only a hit flag and that time stamp. It never stores its own address.

A readout begins when `start` is pulsed in the idle state. A token then moves over the matrix in row-major order and stops only at cells that hold a hit. Edge encoders turn the token position into a column and row. These are shipped together with the cell's stored time stamp as one output word under a valid/ready handshake. While a word waits to be accepted, the search for the next hit cell is already resolved. Each accepted word therefore hands the token straight to the next hit cell, and a new word is offered on the following cycle. After the last hit cell, the controller raises a one-cycle done pulse and returns to idle.

Per-cell kill and inject bits are shifted in serially. A kill bit blocks every hit on its cell. An inject bit makes its cell act as hit in every acquisition cycle.

The controller has three states. `ST_IDLE` is acquisition. `ST_SHIP` presents a word. `ST_DONE` is the done pulse. The transitions are:
- idle to ship: on `start` when a hit exists.
- idle to done: on `start` when the matrix is empty.
- ship to ship: on acceptance when a further hit lies ahead.
- ship to done: on acceptance of the last word.
- done to idle: always, after one cycle.

Top module: `pixro_top`

## Requirements
- R1: After reset, `out_valid` and `done` are low, every hit flag is clear, the kill and inject masks are zero and the time-stamp counter is 0.
- R2: An acquisition cycle is a cycle in `ST_IDLE` with `start` and `mask_load` both low. In each acquisition cycle with `ts_en` high, the counter advances by one and wraps from 31 to 0. A cell hit in an acquisition cycle stores the counter value of that cycle.
- R3: Output word layout is column in bits [5:0], row in bits [11:6] and time stamp in bits [16:12] (in general, column width log2(COLS) at the bottom, then row, then time stamp). Cell index is row*COLS+column. Words appear only for cells holding a hit, in ascending index order.
- R4: With `out_ready` held high, a readout of n hit cells shows valid on n consecutive cycles starting the cycle after `start`, then `done` on the next cycle, with no gap cycles.
- R5: While `out_valid` is high and `out_ready` is low, the word is held unchanged. A cell's hit flag is cleared when its word is accepted, so a following readout does not repeat it.
- R6: `done` is high for exactly one cycle per readout and never together with `out_valid`. Readout of an empty matrix produces only the done pulse.
- R7: A cell that already holds a hit ignores further hits, keeping its first time stamp.
- R8: A kill bit of 1 suppresses both hits and injection on that cell. An inject bit of 1 on an unkilled cell makes the cell take a hit in every acquisition cycle.
- R9: While `mask_load` is high, one kill bit and one inject bit are shifted in per clock. After COLS*ROWS loads, the first bit loaded belongs to cell 0 and the last to cell COLS*ROWS-1. No hit is captured and the counter does not advance during loading.
- R10: Outside acquisition cycles, the counter is frozen and `pix_hit` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_hit | input | COLS*ROWS | Per-cell hit inputs, bit index row*COLS+column |
| mask_load | input | 1 | Shift one kill and one inject bit into the mask chains |
| kill_bit | input | 1 | Serial kill bit |
| inj_bit | input | 1 | Serial inject bit |
| ts_en | input | 1 | Time-stamp counter enable |
| start | input | 1 | Start a readout (honoured in idle) |
| out_word | output | TS_W+log2(ROWS)+log2(COLS) | {time stamp, row, column} |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted when high with valid |
| done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The bench uses an 8x4 matrix. It first hits every cell alone, once each, at steadily growing counter values. This separates errors in the column/row encoding and the word layout from errors in the order of the scan, and it carries the counter past its wrap. The matrix is then filled completely and read with ready held high, which shows whether the look-ahead hands the token over with no lost cycle. Two overlapping patterns, read under stalling ready, check that first hits are kept and that words are held. The remaining patterns cover killed and injected cells, a mask whose only set bit is the last one loaded, and hits applied during readout, which must not appear.

// File: rtl/pixro_pkg.sv
package pixro_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SHIP = 2'd1,
        ST_DONE = 2'd2
    } ro_state_e;
endpackage

// File: rtl/pixro_mask_chain.sv
module pixro_mask_chain #(
    parameter int N = 4096
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         kill_bit,
    input  logic         inj_bit,
    output logic [N-1:0] kill_q,
    output logic [N-1:0] inj_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kill_q <= '0;
            inj_q  <= '0;
        end else if (load) begin
            kill_q <= {kill_bit, kill_q[N-1:1]};
            inj_q  <= {inj_bit,  inj_q[N-1:1]};
        end
    end

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(kill_q) && $stable(inj_q)));
endmodule

// File: rtl/pixro_cell_array.sv
module pixro_cell_array #(
    parameter int N    = 4096,
    parameter int TS_W = 5,
    localparam int AW  = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acq,
    input  logic [TS_W-1:0] ts_val,
    input  logic [N-1:0]    pix_hit,
    input  logic [N-1:0]    kill_q,
    input  logic [N-1:0]    inj_q,
    input  logic            clr_en,
    input  logic [AW-1:0]   clr_idx,
    output logic [N-1:0]    hit_q,
    output logic [N*TS_W-1:0] ts_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= '0;
            ts_q  <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (clr_en && clr_idx == AW'(i)) begin
                    hit_q[i] <= 1'b0;
                end else if (acq && !hit_q[i] && !kill_q[i] && (pix_hit[i] || inj_q[i])) begin
                    hit_q[i]               <= 1'b1;
                    ts_q[i*TS_W +: TS_W]   <= ts_val;
                end
            end
        end
    end

    // R5
    clear_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> hit_q[clr_idx]);
    // R10
    no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq && !clr_en) |=> $stable(hit_q));
endmodule

// File: rtl/pixro_token_seek.sv
module pixro_token_seek #(
    parameter int COLS = 64,
    parameter int ROWS = 64,
    localparam int N   = COLS * ROWS,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS)
) (
    input  logic [N-1:0]  hits,
    input  logic [RW-1:0] base_row,
    input  logic [CW-1:0] base_col,
    input  logic          incl,
    output logic          found,
    output logic [RW-1:0] f_row,
    output logic [CW-1:0] f_col
);
    logic [ROWS-1:0] row_any;

    for (genvar r = 0; r < ROWS; r++) begin : g_row_or
        assign row_any[r] = |hits[r*COLS +: COLS];
    end

    logic [COLS-1:0] same_bits, next_bits;
    logic            sr_found, nr_found;
    logic [CW-1:0]   sr_col, nr_col;
    logic [RW-1:0]   nr_row;

    always_comb begin
        same_bits = hits[int'(base_row)*COLS +: COLS];
        sr_found  = 1'b0;
        sr_col    = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (same_bits[c] && (c > int'(base_col) || (incl && c == int'(base_col)))) begin
                sr_found = 1'b1;
                sr_col   = CW'(c);
            end
        end
        nr_found = 1'b0;
        nr_row   = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (row_any[r] && r > int'(base_row)) begin
                nr_found = 1'b1;
                nr_row   = RW'(r);
            end
        end
        next_bits = hits[int'(nr_row)*COLS +: COLS];
        nr_col    = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (next_bits[c]) nr_col = CW'(c);
        end
        found = sr_found || nr_found;
        f_row = sr_found ? base_row : nr_row;
        f_col = sr_found ? sr_col : nr_col;
    end
endmodule

// File: rtl/pixro_top.sv
module pixro_top #(
    parameter int COLS = 64,
    parameter int ROWS = 64,
    parameter int TS_W = 5,
    localparam int N   = COLS * ROWS,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS),
    localparam int AW  = CW + RW,
    localparam int WW  = TS_W + RW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pix_hit,
    input  logic          mask_load,
    input  logic          kill_bit,
    input  logic          inj_bit,
    input  logic          ts_en,
    input  logic          start,
    output logic [WW-1:0] out_word,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          done
);
    import pixro_pkg::*;

    ro_state_e       state_q, state_d;
    logic [RW-1:0]   cur_row;
    logic [CW-1:0]   cur_col;
    logic [AW-1:0]   cur_idx;
    logic [TS_W-1:0] ts_cnt;
    logic            acq, accept, load_pos;
    logic [N-1:0]    kill_q, inj_q, hit_q;
    logic [N*TS_W-1:0] ts_q;
    logic            found;
    logic [RW-1:0]   f_row, s_row;
    logic [CW-1:0]   f_col, s_col;
    logic            s_incl;

    assign acq      = (state_q == ST_IDLE) && !start && !mask_load;
    assign accept   = (state_q == ST_SHIP) && out_ready;
    assign load_pos = ((state_q == ST_IDLE) && start) || accept;
    assign cur_idx  = AW'(int'(cur_row) * COLS + int'(cur_col));
    assign s_incl   = (state_q == ST_IDLE);
    assign s_row    = s_incl ? '0 : cur_row;
    assign s_col    = s_incl ? '0 : cur_col;

    pixro_mask_chain #(.N(N)) u_masks (
        .clk(clk), .rst_n(rst_n), .load(mask_load),
        .kill_bit(kill_bit), .inj_bit(inj_bit),
        .kill_q(kill_q), .inj_q(inj_q)
    );

    pixro_cell_array #(.N(N), .TS_W(TS_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .acq(acq), .ts_val(ts_cnt),
        .pix_hit(pix_hit), .kill_q(kill_q), .inj_q(inj_q),
        .clr_en(accept), .clr_idx(cur_idx),
        .hit_q(hit_q), .ts_q(ts_q)
    );

    pixro_token_seek #(.COLS(COLS), .ROWS(ROWS)) u_seek (
        .hits(hit_q), .base_row(s_row), .base_col(s_col), .incl(s_incl),
        .found(found), .f_row(f_row), .f_col(f_col)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = found ? ST_SHIP : ST_DONE;
            ST_SHIP: if (out_ready) state_d = found ? ST_SHIP : ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // token position and time-stamp counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row <= '0;
            cur_col <= '0;
            ts_cnt  <= '0;
        end else begin
            if (load_pos && found) begin
                cur_row <= f_row;
                cur_col <= f_col;
            end
            if (acq && ts_en) ts_cnt <= ts_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_SHIP);
        done      = (state_q == ST_DONE);
        out_word  = {ts_q[cur_idx*TS_W +: TS_W], cur_row, cur_col};
    end

    // R6
    done_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && out_valid));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
    // R10
    ts_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(ts_cnt));
    // R2
    ts_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq && ts_en && ts_cnt == '1) |=> (ts_cnt == '0));
endmodule

// File: tb/pixro_top_tb.sv
module pixro_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COLS = 8;
    localparam int ROWS = 4;
    localparam int TS_W = 5;
    localparam int N    = COLS * ROWS;
    localparam int CW   = 3;
    localparam int RW   = 2;
    localparam int WW   = TS_W + RW + CW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  pix_hit;
    logic          mask_load, kill_bit, inj_bit, ts_en, start, out_ready;
    logic [WW-1:0] out_word;
    logic          out_valid, done;

    pixro_top #(.COLS(COLS), .ROWS(ROWS), .TS_W(TS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_hit(pix_hit), .mask_load(mask_load),
        .kill_bit(kill_bit), .inj_bit(inj_bit), .ts_en(ts_en), .start(start),
        .out_word(out_word), .out_valid(out_valid), .out_ready(out_ready), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int       checks = 0;
    int       errs   = 0;
    bit       finished = 1'b0;
    bit [N-1:0] m_hit, m_kill, m_inj;
    bit [4:0] m_ts [N];
    bit [4:0] cnt;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one acquisition cycle with the given hit pattern (R2, R7, R8 model)
    task automatic step(input logic [N-1:0] pat);
        pix_hit = pat;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (!m_hit[i] && !m_kill[i] && (pat[i] || m_inj[i])) begin
                m_hit[i] = 1'b1;
                m_ts[i]  = cnt;
            end
        end
        if (ts_en) cnt = cnt + 5'd1;
        @(negedge clk);
        pix_hit = '0;
    endtask

    // R9: serial mask load, first bit to cell 0
    task automatic load_masks(input logic [N-1:0] k, input logic [N-1:0] inj);
        mask_load = 1'b1;
        for (int j = 0; j < N; j++) begin
            kill_bit = k[j];
            inj_bit  = inj[j];
            @(posedge clk);
            @(negedge clk);
        end
        mask_load = 1'b0;
        kill_bit  = 1'b0;
        inj_bit   = 1'b0;
        m_kill = k;
        m_inj  = inj;
    endtask

    // readout: bp stalls ready, noise drives hits during readout (R10)
    task automatic readout(input bit bp, input bit noise);
        int  nexp = 0;
        int  cycles = 0;
        bit  held = 1'b0;
        logic [WW-1:0] prev = '0;
        int  idx;
        bit  r;
        for (int i = 0; i < N; i++) if (m_hit[i]) nexp++;
        start = 1'b1;
        if (noise) pix_hit = '1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int guard = 0; guard < 4 * N + 10; guard++) begin
            cycles++;
            if (done) begin
                check("R6 done without valid", {31'd0, out_valid}, 32'd0);
                check("R6 no words left at done", {31'd0, |m_hit}, 32'd0);
                if (!bp) check("R4 cycles to done", cycles, nexp + 1);
                break;
            end else if (out_valid) begin
                idx = -1;
                for (int i = N - 1; i >= 0; i--) if (m_hit[i]) idx = i;
                if (idx < 0) begin
                    check("R6 extra word", 32'd1, 32'd0);
                    r = 1'b1;
                end else begin
                    check("R3 word", out_word,
                          (32'(m_ts[idx]) << (CW + RW)) | (32'(idx / COLS) << CW) | 32'(idx % COLS));
                    if (held) check("R5 held word", out_word, prev);
                    r = bp ? (cycles % 3 != 0) : 1'b1;
                    if (r) m_hit[idx] = 1'b0;
                end
                out_ready = r;
                held = !r;
                prev = out_word;
            end else begin
                check("R4 gap cycle", 32'd1, 32'd0);
            end
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        pix_hit   = '0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pix_hit = '0; mask_load = 0; kill_bit = 0; inj_bit = 0;
        ts_en = 1'b1; start = 0; out_ready = 0;
        m_hit = '0; m_kill = '0; m_inj = '0; cnt = '0;
        for (int i = 0; i < N; i++) m_ts[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        // R6 empty matrix gives only done; R1 empty after reset
        readout(1'b0, 1'b0);

        // R2 R3: each cell alone, counter climbs past wrap
        for (int c = 0; c < N; c++) begin
            for (int k = 0; k < c % 3; k++) step('0);
            step(N'(1) << c);
            readout(1'b0, 1'b0);
        end

        // R4: full matrix, ready held, back to back
        step('1);
        readout(1'b0, 1'b0);
        // R5: flags cleared, second readout empty
        readout(1'b0, 1'b0);

        // R7 first hit kept, R5 stall hold
        step(32'hA5A5_5A5A);
        step('0);
        step(32'hFF00_FF00);
        readout(1'b1, 1'b0);

        // R10 hits during readout ignored
        step(32'h0000_0110);
        readout(1'b0, 1'b1);
        readout(1'b0, 1'b0);

        // R8 kill and inject
        load_masks(32'h0000_0041, 32'h0000_0240);
        step('1);
        readout(1'b1, 1'b0);
        step('0);
        step('0);
        readout(1'b0, 1'b0);   // R8 injected cell 9 hit again

        // R9 order: only last loaded inject bit set -> last cell
        load_masks('0, 32'h8000_0000);
        step('0);
        readout(1'b0, 1'b0);
        load_masks('0, '0);
        readout(1'b0, 1'b0);   // R9 nothing captured during load

        // R2 explicit wrap 31 -> 0
        while (cnt != 5'd31) step('0);
        step(N'(1) << 12);
        step(N'(1) << 13);
        check("R2 model wrap", {27'd0, m_ts[13]}, 32'd0);
        readout(1'b0, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end
endmodule